// File: doc/BRIEF.md
# Full-Scan Test Sequence Controller

This block runs a complete full-scan test on a mux-D scan chain that surrounds a combinational core. Each scan flip-flop takes functional data in normal mode and serial data in scan mode. The controller steps through a fixed list of combinational test vectors held in a parameter. For each vector it does three things:

- It shifts the vector's state part into the chain with the test-control line low.
- It raises test control for one capture clock. In that cycle it drives the vector's primary inputs and compares the core's primary outputs with the expected values.
- While the next vector shifts in, it reads the captured next-state serially from the chain end and compares it bit by bit.

After the last capture, one more unload pass empties the chain, and the sequence ends. The controller keeps a sticky pass/fail result together with the index of the first failing vector. A done flag marks the end of the run.

A single start pulse begins a run from idle or from done. An active-low synchronous reset returns the controller to idle at any time.

Top module: `scan_test_seq`

## Requirements
- R1: While rstN is low at a clock edge, the next cycle shows testCtrl=0, scanIn=0, piOut=0, done=0, fail=0 and failIdx=0.
- R2: A start seen in idle or done starts a run. The run has exactly (NCOMB+1)*NSFF+NCOMB active cycles, after which done goes high and stays high until the next start or reset.
- R3: In a run, testCtrl is high for exactly NCOMB single cycles. Each of these pulses, and the end of the run, comes after exactly NSFF cycles with testCtrl low.
- R4: During the load of a vector, scanIn carries its state field most significant bit first. After NSFF shifts, state bit i sits in chain stage i, where stage 0 is fed by scanIn and stage NSFF-1 drives scanOut.
- R5: piOut carries the current vector's input field during its capture cycle and is zero in every other cycle.
- R6: During a capture cycle, poIn is compared with the vector's expected-output field. Any difference marks that vector as failing.
- R7: While vector k+1 loads, the response to vector k is unloaded. Each scanOut bit is compared with the expected next-state field, bit NSFF-1 first. A difference marks vector k as failing.
- R8: After the last capture, a final NSFF-cycle unload is still compared, and scanIn is driven to zero throughout it.
- R9: fail is sticky. failIdx holds the index of the first failing vector, and both are cleared when a new run starts.
- R10: PATTERNS packs NCOMB words of 2*NSFF+NPI+NPO bits each, with vector 0 in the least significant word. Each word holds, from most to least significant: state, inputs, expected outputs, expected next-state.
- R11: A start pulse during a run is ignored and the run length is unchanged.
- R12: A reset during a run aborts it. The controller then stays idle, with no capture pulses, until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a test run |
| scanOut | input | 1 | Serial data from the last chain stage |
| poIn | input | NPO | Primary outputs of the core |
| testCtrl | output | 1 | Chain mode: 0 shift, 1 capture |
| scanIn | output | 1 | Serial data into the first chain stage |
| piOut | output | NPI | Primary inputs applied to the core |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |
| failIdx | output | $clog2(NCOMB+1) | Index of the first failing vector |

## Verification
A bit counter that slips shows at the ports straight away. The testCtrl pulses move off their NSFF spacing, the run length changes, and the chain holds a rotated state by the first capture, NSFF+1 cycles after start. A vector counter that is off by one puts the wrong inputs on piOut at the very next capture. It also makes a clean core look faulty within one unload pass. A fail latch that overwrites or drops its index shows as a wrong failIdx as soon as a later fault follows an earlier one in the same run.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPTURE,
    ST_DONE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureOn;    // capture cycle, testCtrl high
    logic loadValid;    // shift cycle that loads a real vector bit
    logic checkUnload;  // shift cycle whose scanOut bit is compared
    logic clearRes;     // a new run is starting
  } seqStrobe_t;

endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NSFF  = 4,
  parameter int NCOMB = 4,
  localparam int BW = (NSFF > 1) ? $clog2(NSFF) : 1,
  localparam int VW = $clog2(NCOMB + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output seqStrobe_t    strobe,
  output logic [BW-1:0] bitIdx,
  output logic [VW-1:0] vecIdx,
  output logic          done
);

  localparam logic [BW-1:0] LAST_BIT = BW'(NSFF - 1);
  localparam logic [VW-1:0] LAST_VEC = VW'(NCOMB);

  seqState_e     state;
  logic [BW-1:0] bitCnt;
  logic [VW-1:0] vecCnt;
  logic          unloading;
  logic          idleLike;

  assign idleLike = (state == ST_IDLE) || (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      vecCnt    <= '0;
      unloading <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state     <= ST_SHIFT;
            bitCnt    <= '0;
            vecCnt    <= '0;
            unloading <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (bitCnt == LAST_BIT) begin
            bitCnt <= '0;
            state  <= (vecCnt == LAST_VEC) ? ST_DONE : ST_CAPTURE;
          end else begin
            bitCnt <= bitCnt + BW'(1);
          end
        end
        ST_CAPTURE: begin
          vecCnt    <= vecCnt + VW'(1);
          unloading <= 1'b1;
          state     <= ST_SHIFT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.captureOn   = (state == ST_CAPTURE);
    strobe.loadValid   = (state == ST_SHIFT) && (vecCnt != LAST_VEC);
    strobe.checkUnload = (state == ST_SHIFT) && unloading;
    strobe.clearRes    = idleLike && start;
  end

  assign bitIdx = bitCnt;
  assign vecIdx = vecCnt;
  assign done   = (state == ST_DONE);

  // R3
  tc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureOn |=> !strobe.captureOn && (bitIdx == '0));

  // R2
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) && (bitIdx != LAST_BIT) |=> !done && !idleLike);

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= LAST_BIT);

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> !done && !strobe.captureOn);

endmodule

// File: rtl/scan_seq_dp.sv
module scan_seq_dp
  import scan_seq_pkg::*;
#(
  parameter int NSFF  = 4,
  parameter int NCOMB = 4,
  parameter int NPI   = 3,
  parameter int NPO   = 2,
  localparam int VECW = 2 * NSFF + NPI + NPO,
  parameter logic [NCOMB*VECW-1:0] PATTERNS = '0,
  localparam int BW = (NSFF > 1) ? $clog2(NSFF) : 1,
  localparam int VW = $clog2(NCOMB + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  seqStrobe_t     strobe,
  input  logic [BW-1:0]  bitIdx,
  input  logic [VW-1:0]  vecIdx,
  input  logic           scanOut,
  input  logic [NPO-1:0] poIn,
  output logic           scanIn,
  output logic [NPI-1:0] piOut,
  output logic           fail,
  output logic [VW-1:0]  failIdx
);

  localparam int NEXT_LO = 0;
  localparam int EPO_LO  = NSFF;
  localparam int PI_LO   = NSFF + NPO;
  localparam int ST_LO   = NSFF + NPO + NPI;
  localparam logic [VW-1:0] LAST_VEC = VW'(NCOMB);

  logic [VECW-1:0] vecMem [NCOMB];

  for (genvar g = 0; g < NCOMB; g++) begin : g_unpack
    assign vecMem[g] = PATTERNS[g*VECW +: VECW];
  end

  logic [VECW-1:0] curWord, prevWord;

  // curWord: vector being loaded/captured; prevWord: vector being unloaded
  always_comb begin
    curWord  = '0;
    prevWord = '0;
    for (int k = 0; k < NCOMB; k++) begin
      if (vecIdx == VW'(k))     curWord  = vecMem[k];
      if (vecIdx == VW'(k + 1)) prevWord = vecMem[k];
    end
  end

  logic [NSFF-1:0] curState, expNext;
  logic [NPI-1:0]  curPi;
  logic [NPO-1:0]  curExpPo;

  assign curState = curWord[ST_LO +: NSFF];
  assign curPi    = curWord[PI_LO +: NPI];
  assign curExpPo = curWord[EPO_LO +: NPO];
  assign expNext  = prevWord[NEXT_LO +: NSFF];

  logic loadBit, unloadBit;

  // shift cycle j carries bit NSFF-1-j in both directions
  always_comb begin
    loadBit   = 1'b0;
    unloadBit = 1'b0;
    for (int j = 0; j < NSFF; j++) begin
      if (bitIdx == BW'(j)) begin
        loadBit   = curState[NSFF-1-j];
        unloadBit = expNext[NSFF-1-j];
      end
    end
  end

  assign scanIn = strobe.loadValid ? loadBit : 1'b0;
  assign piOut  = strobe.captureOn ? curPi : '0;

  logic poMiss, stMiss;
  assign poMiss = strobe.captureOn && (poIn != curExpPo);
  assign stMiss = strobe.checkUnload && (scanOut != unloadBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fail    <= 1'b0;
      failIdx <= '0;
    end else if (strobe.clearRes) begin
      fail    <= 1'b0;
      failIdx <= '0;
    end else if (!fail && (poMiss || stMiss)) begin
      fail    <= 1'b1;
      failIdx <= poMiss ? vecIdx : vecIdx - VW'(1);
    end
  end

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail && !strobe.clearRes |=> fail && $stable(failIdx));

  // R9
  fail_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> failIdx < LAST_VEC);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> !fail && (failIdx == '0));

  // R5
  pi_capture_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.captureOn) |-> piOut == '0);

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int NSFF  = 4,
  parameter int NCOMB = 4,
  parameter int NPI   = 3,
  parameter int NPO   = 2,
  localparam int VECW = 2 * NSFF + NPI + NPO,
  parameter logic [NCOMB*VECW-1:0] PATTERNS = '0,
  localparam int BW = (NSFF > 1) ? $clog2(NSFF) : 1,
  localparam int VW = $clog2(NCOMB + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           scanOut,
  input  logic [NPO-1:0] poIn,
  output logic           testCtrl,
  output logic           scanIn,
  output logic [NPI-1:0] piOut,
  output logic           done,
  output logic           fail,
  output logic [VW-1:0]  failIdx
);

  seqStrobe_t    strobe;
  logic [BW-1:0] bitIdx;
  logic [VW-1:0] vecIdx;

  scan_seq_ctrl #(.NSFF(NSFF), .NCOMB(NCOMB)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .bitIdx (bitIdx),
    .vecIdx (vecIdx),
    .done   (done)
  );

  scan_seq_dp #(
    .NSFF(NSFF), .NCOMB(NCOMB), .NPI(NPI), .NPO(NPO), .PATTERNS(PATTERNS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bitIdx  (bitIdx),
    .vecIdx  (vecIdx),
    .scanOut (scanOut),
    .poIn    (poIn),
    .scanIn  (scanIn),
    .piOut   (piOut),
    .fail    (fail),
    .failIdx (failIdx)
  );

  assign testCtrl = strobe.captureOn;

endmodule

// File: tb/scan_test_seq_test.sv
module scan_test_seq_test;

  localparam int NSFF  = 4;
  localparam int NCOMB = 4;
  localparam int NPI   = 3;
  localparam int NPO   = 2;
  localparam int VECW  = 2 * NSFF + NPI + NPO;
  localparam int VW    = $clog2(NCOMB + 1);
  localparam int RUNLEN = (NCOMB + 1) * NSFF + NCOMB;

  // stimulus table: {state, inputs} per vector
  localparam logic [NSFF+NPI-1:0] STIM [NCOMB] = '{
    7'b1010_101, 7'b0111_010, 7'b1100_111, 7'b0001_000
  };

  function automatic logic [NSFF-1:0] nextFn(logic [NSFF-1:0] s, logic [NPI-1:0] p);
    return {s[2:0], s[3] ^ p[0]} ^ {1'b0, p};
  endfunction

  function automatic logic [NPO-1:0] poFn(logic [NSFF-1:0] s, logic [NPI-1:0] p);
    return {^{s, p}, (s[0] & p[1]) | s[3]};
  endfunction

  function automatic logic [NCOMB*VECW-1:0] buildPatterns();
    logic [NCOMB*VECW-1:0] r;
    r = '0;
    for (int k = 0; k < NCOMB; k++) begin
      logic [NSFF-1:0] s;
      logic [NPI-1:0]  p;
      s = STIM[k][NPI +: NSFF];
      p = STIM[k][0 +: NPI];
      r[k*VECW +: VECW] = {s, p, poFn(s, p), nextFn(s, p)};
    end
    return r;
  endfunction

  localparam logic [NCOMB*VECW-1:0] PATS = buildPatterns();

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic           scanOut;
  logic [NPO-1:0] poIn;
  logic           testCtrl, scanIn, done, fail;
  logic [NPI-1:0] piOut;
  logic [VW-1:0]  failIdx;

  always #4 clk = ~clk;

  scan_test_seq #(
    .NSFF(NSFF), .NCOMB(NCOMB), .NPI(NPI), .NPO(NPO), .PATTERNS(PATS)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .scanOut(scanOut), .poIn(poIn),
    .testCtrl(testCtrl), .scanIn(scanIn), .piOut(piOut),
    .done(done), .fail(fail), .failIdx(failIdx)
  );

  // scan chain and core model with fault injection
  logic [NSFF-1:0] chain = '0;
  int              modelCap = 0;
  int              poFaultVec = -1;
  int              nsFaultVec = -1;
  logic [NPO-1:0]  poFlip = '0;
  logic [NSFF-1:0] nsFlip = '0;

  always @(posedge clk) begin
    if (testCtrl) begin
      chain    <= nextFn(chain, piOut) ^ ((modelCap == nsFaultVec) ? nsFlip : '0);
      modelCap <= modelCap + 1;
    end else begin
      chain <= {chain[NSFF-2:0], scanIn};
    end
  end

  assign scanOut = chain[NSFF-1];
  always_comb poIn = poFn(chain, piOut) ^ ((testCtrl && modelCap == poFaultVec) ? poFlip : '0);

  int total = 0;
  int bad = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one run; all captures and spacing monitored on the way
  task automatic runSeq(input int poV, input logic [NPO-1:0] poF,
                        input int nsV, input logic [NSFF-1:0] nsF,
                        input bit midStart, output int cycles);
    int capSeen = 0;
    int lowRun = 0;
    int piBad = 0;
    int tailBad = 0;
    cycles = 0;
    poFaultVec = poV; poFlip = poF;
    nsFaultVec = nsV; nsFlip = nsF;
    modelCap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cycles < 300) begin
      if (testCtrl) begin
        chk(piOut == STIM[capSeen][0 +: NPI], "R5 piOut at capture", piOut, STIM[capSeen][0 +: NPI]);
        chk(chain == STIM[capSeen][NPI +: NSFF], "R4 chain state at capture", chain, STIM[capSeen][NPI +: NSFF]);
        chk(lowRun == NSFF, "R3 shift cycles before capture", lowRun, NSFF);
        lowRun = 0;
        capSeen++;
      end else begin
        lowRun++;
        if (piOut != '0) piBad++;
        if (capSeen == NCOMB && scanIn != 1'b0) tailBad++;
      end
      cycles++;
      start = midStart && (cycles == 10);
      @(negedge clk);
    end
    start = 1'b0;
    if (cycles >= 300) chk(1'b0, "R2 watchdog run hung", cycles, RUNLEN);
    chk(capSeen == NCOMB, "R3 capture pulse count", capSeen, NCOMB);
    chk(lowRun == NSFF, "R8 final unload length", lowRun, NSFF);
    chk(piBad == 0, "R5 piOut zero outside capture", piBad, 0);
    chk(tailBad == 0, "R8 scanIn zero in final unload", tailBad, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!testCtrl && !scanIn && piOut == '0, "R1 idle outputs", {testCtrl, scanIn, piOut}, 0);
    chk(!done && !fail && failIdx == '0, "R1 result flags", {done, fail, failIdx}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // clean run: R2, R6, R7, R10
    runSeq(-1, '0, -1, '0, 1'b0, cyc);
    chk(cyc == RUNLEN, "R2 run length", cyc, RUNLEN);
    chk(done && !fail, "R10 clean patterns pass", {done, fail}, 2);
    repeat (3) @(negedge clk);
    chk(done, "R2 done held", done, 1);

    // output fault on vector 2
    runSeq(2, 2'b01, -1, '0, 1'b0, cyc);
    chk(fail && failIdx == 2, "R6 output mismatch index", failIdx, 2);

    // next-state fault on vector 1 bit 3 and output fault on vector 3
    runSeq(3, 2'b10, 1, 4'b1000, 1'b0, cyc);
    chk(fail && failIdx == 1, "R9 first failing vector kept", failIdx, 1);
    chk(fail, "R7 next-state mismatch", fail, 1);

    // next-state fault in last vector, bit 0: seen only in final unload
    runSeq(-1, '0, 3, 4'b0001, 1'b0, cyc);
    chk(fail && failIdx == 3, "R8 final unload compared", failIdx, 3);

    // restart clears result; start during run ignored
    runSeq(-1, '0, -1, '0, 1'b1, cyc);
    chk(!fail && failIdx == 0, "R9 cleared on new run", {fail, failIdx}, 0);
    chk(cyc == RUNLEN, "R11 start mid-run ignored", cyc, RUNLEN);

    // reset in the middle of a run
    modelCap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    begin
      int tcSeen = 0;
      int doneSeen = 0;
      for (int i = 0; i < 12; i++) begin
        if (testCtrl) tcSeen++;
        if (done) doneSeen++;
        @(negedge clk);
      end
      chk(tcSeen == 0, "R12 no capture after reset", tcSeen, 0);
      chk(doneSeen == 0 && !fail, "R12 idle after reset", doneSeen, 0);
    end

    // run works again after reset
    runSeq(-1, '0, -1, '0, 1'b0, cyc);
    chk(cyc == RUNLEN && !fail, "R2 run after reset", cyc, RUNLEN);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule